// File: doc/BRIEF.md
# Maskable Interrupt Acknowledge Controller

This block chooses which pending maskable interrupt request the processor takes next. Each source raises a one-cycle set pulse that is held in a request flag inside the block. Each source also drives a 3-bit priority level. Level 0 is the most urgent and level 7 the least. The block keeps an 8-bit in-service register, with one bit per priority level, that records the levels currently being handled. It also keeps a global disable flag. When the disable flag is 1, no maskable request is taken.

The block grants a request only when the disable flag is clear and the request's level is strictly more urgent than every level already in service. This is what allows handlers to nest. A grant does three things at the next clock edge: it marks the level in service, clears the source's request flag and sets the disable flag. Return-from-interrupt pulses release in-service levels, but only when the return comes from maskable service. Enable, disable and status-restore inputs drive the disable flag. Non-maskable and exception acknowledge pulses leave all of this state untouched.

Top module: `mask_irq_arbiter`

## Requirements
- R1: After reset, `inService` is 0x00, `intDisable` is 1, no request flag is pending and `ackValid` is 0.
- R2: A `reqSet[i]` pulse sets request flag i, and the flag stays set until source i is granted. The grant clears the flag at the clock edge that ends the grant cycle. A `reqSet[i]` pulse in the grant cycle of source i leaves the flag set.
- R3: `ackValid` and `ackSrc` are combinational outputs in the same cycle. Among eligible requests the numerically lowest level wins. Within one level the lowest source index wins. The level of source i is `reqPrio[3*i+2:3*i]`.
- R4: A pending request is eligible only if its level number is strictly less than the lowest-numbered bit set in `inService`. When `inService` is zero, every pending request is eligible.
- R5: No grant occurs while `intDisable` is 1, or in a cycle where `nmiAck` or `excAck` is 1. The request stays pending in both cases.
- R6: A grant sets `inService[level]` at the clock edge after the grant cycle. During the grant cycle `inService` still shows the value from before the grant.
- R7: A grant sets `intDisable` to 1 at the same edge. This overrides any `flagWrEn`, `cmdDi` or `cmdEi` in that cycle.
- R8: In a cycle without a grant, `intDisable` is updated in this order of priority: `flagWrEn` loads `flagWrData` first, then `cmdDi` sets the flag, then `cmdEi` clears it. With none of these, the flag holds.
- R9: `cmdReti` with `retiMaskable`=1 clears only the lowest-numbered set bit of `inService` at the next edge. When `inService` is zero it changes nothing.
- R10: `cmdReti` with `retiMaskable`=0 leaves `inService` unchanged. `nmiAck` and `excAck` change neither `inService` nor `intDisable`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqSet | input | NUM_SRC | Per-source request set pulses |
| reqPrio | input | 3*NUM_SRC | Per-source priority levels, 3 bits each |
| cmdDi | input | 1 | Disable command pulse |
| cmdEi | input | 1 | Enable command pulse |
| cmdReti | input | 1 | Return-from-interrupt pulse |
| retiMaskable | input | 1 | Return qualifier: 1 means the return is from maskable service |
| flagWrEn | input | 1 | Status write strobe for the disable flag |
| flagWrData | input | 1 | Value loaded by the status write |
| nmiAck | input | 1 | Non-maskable acknowledge pulse |
| excAck | input | 1 | Exception acknowledge pulse |
| ackValid | output | 1 | Grant strobe |
| ackSrc | output | clog2(NUM_SRC) | Index of the granted source |
| inService | output | 8 | In-service register, one bit per level |
| intDisable | output | 1 | Global maskable disable flag |

## Verification
The grant strobe and source index depend combinationally on the current inputs and the registered state, so they are due in the same cycle as the stimulus. The in-service register, the request flags and the disable flag change one edge later. The bench drives every input on the falling edge and compares the grant outputs 1 ns later against a reference model held in the bench. It advances the model at the rising edge, so the register outputs are compared on the following cycle. Directed sequences cover nesting, tie-breaking within a level, blocking by the non-maskable and exception acknowledges, both kinds of return, and collisions on the flag inputs. Seeded random traffic then covers mixed command patterns.

// File: rtl/mirq_pkg.sv
package mirq_pkg;
  localparam int PRIO_W = 3;
  localparam int LEVELS = 1 << PRIO_W;

  typedef logic [PRIO_W-1:0] prio_t;
  typedef logic [LEVELS-1:0] lvlMask_t;

  // strobes from control to datapath for one clock edge
  typedef struct packed {
    logic     ack;
    lvlMask_t isrSet;
    lvlMask_t isrClr;
    logic     disWe;
    logic     disVal;
  } ctrlStrobe_t;
endpackage

// File: rtl/mirq_ctrl.sv
module mirq_ctrl
  import mirq_pkg::*;
#(
  parameter int NUM_SRC = 8,
  localparam int SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0]        pendQ,
  input  logic [NUM_SRC*PRIO_W-1:0] reqPrio,
  input  lvlMask_t                  isrQ,
  input  logic                      disQ,
  input  logic                      cmdDi,
  input  logic                      cmdEi,
  input  logic                      cmdReti,
  input  logic                      retiMaskable,
  input  logic                      flagWrEn,
  input  logic                      flagWrData,
  input  logic                      nmiAck,
  input  logic                      excAck,
  output ctrlStrobe_t               strb,
  output logic [SRC_W-1:0]          winSrc
);
  logic [PRIO_W:0]    ceilLvl;
  prio_t              srcPrio [NUM_SRC];
  logic [NUM_SRC-1:0] eligible;
  logic               found;
  prio_t              bestPrio;
  logic               ackNow;
  lvlMask_t           lowBit;

  // lowest-numbered in-service level forms the nesting ceiling
  always_comb begin
    ceilLvl = (PRIO_W+1)'(LEVELS);
    for (int l = LEVELS-1; l >= 0; l--) begin
      if (isrQ[l]) ceilLvl = (PRIO_W+1)'(l);
    end
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : gElig
    assign srcPrio[g]  = reqPrio[g*PRIO_W +: PRIO_W];
    assign eligible[g] = pendQ[g] && ({1'b0, srcPrio[g]} < ceilLvl);
  end

  // strict less-than keeps the lowest index on a tie
  always_comb begin
    found    = 1'b0;
    bestPrio = '0;
    winSrc   = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (eligible[i] && (!found || srcPrio[i] < bestPrio)) begin
        found    = 1'b1;
        bestPrio = srcPrio[i];
        winSrc   = SRC_W'(i);
      end
    end
  end

  assign ackNow = found && !disQ && !nmiAck && !excAck;
  assign lowBit = isrQ & (~isrQ + lvlMask_t'(1));

  always_comb begin
    strb.ack    = ackNow;
    strb.isrSet = ackNow ? (lvlMask_t'(1) << bestPrio) : '0;
    strb.isrClr = (cmdReti && retiMaskable) ? lowBit : '0;
    if (ackNow) begin
      strb.disWe  = 1'b1;
      strb.disVal = 1'b1;
    end else if (flagWrEn) begin
      strb.disWe  = 1'b1;
      strb.disVal = flagWrData;
    end else if (cmdDi) begin
      strb.disWe  = 1'b1;
      strb.disVal = 1'b1;
    end else if (cmdEi) begin
      strb.disWe  = 1'b1;
      strb.disVal = 1'b0;
    end else begin
      strb.disWe  = 1'b0;
      strb.disVal = 1'b0;
    end
  end
endmodule

// File: rtl/mirq_dp.sv
module mirq_dp
  import mirq_pkg::*;
#(
  parameter int NUM_SRC = 8,
  localparam int SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] reqSet,
  input  ctrlStrobe_t        strb,
  input  logic [SRC_W-1:0]   winSrc,
  output logic [NUM_SRC-1:0] pendQ,
  output lvlMask_t           isrQ,
  output logic               disQ
);
  logic [NUM_SRC-1:0] pendNext;

  for (genvar g = 0; g < NUM_SRC; g++) begin : gPend
    assign pendNext[g] = reqSet[g] |
                         (pendQ[g] & ~(strb.ack && (winSrc == SRC_W'(g))));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pendQ <= '0;
      isrQ  <= '0;
      disQ  <= 1'b1;
    end else begin
      pendQ <= pendNext;
      isrQ  <= (isrQ & ~strb.isrClr) | strb.isrSet;
      if (strb.disWe) disQ <= strb.disVal;
    end
  end
endmodule

// File: rtl/mask_irq_arbiter.sv
module mask_irq_arbiter
  import mirq_pkg::*;
#(
  parameter int NUM_SRC = 8,
  localparam int SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_SRC-1:0]        reqSet,
  input  logic [NUM_SRC*PRIO_W-1:0] reqPrio,
  input  logic                      cmdDi,
  input  logic                      cmdEi,
  input  logic                      cmdReti,
  input  logic                      retiMaskable,
  input  logic                      flagWrEn,
  input  logic                      flagWrData,
  input  logic                      nmiAck,
  input  logic                      excAck,
  output logic                      ackValid,
  output logic [SRC_W-1:0]          ackSrc,
  output logic [LEVELS-1:0]         inService,
  output logic                      intDisable
);
  ctrlStrobe_t        strb;
  logic [NUM_SRC-1:0] pendQ;
  lvlMask_t           isrQ;
  logic               disQ;
  logic [SRC_W-1:0]   winSrc;

  mirq_ctrl #(.NUM_SRC(NUM_SRC)) uCtrl (
    .pendQ(pendQ), .reqPrio(reqPrio), .isrQ(isrQ), .disQ(disQ),
    .cmdDi(cmdDi), .cmdEi(cmdEi), .cmdReti(cmdReti),
    .retiMaskable(retiMaskable), .flagWrEn(flagWrEn),
    .flagWrData(flagWrData), .nmiAck(nmiAck), .excAck(excAck),
    .strb(strb), .winSrc(winSrc)
  );

  mirq_dp #(.NUM_SRC(NUM_SRC)) uDp (
    .clk(clk), .rst_n(rst_n), .reqSet(reqSet), .strb(strb),
    .winSrc(winSrc), .pendQ(pendQ), .isrQ(isrQ), .disQ(disQ)
  );

  assign ackValid   = strb.ack;
  assign ackSrc     = winSrc;
  assign inService  = isrQ;
  assign intDisable = disQ;
endmodule

// File: rtl/mask_irq_arbiter_chk.sv
module mask_irq_arbiter_chk
  import mirq_pkg::*;
#(
  parameter int NUM_SRC = 8,
  localparam int SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [NUM_SRC*PRIO_W-1:0] reqPrio,
  input logic                      cmdDi,
  input logic                      cmdReti,
  input logic                      retiMaskable,
  input logic                      flagWrEn,
  input logic                      nmiAck,
  input logic                      excAck,
  input logic                      ackValid,
  input logic [SRC_W-1:0]          ackSrc,
  input logic [LEVELS-1:0]         inService,
  input logic                      intDisable
);
  prio_t    ackLvl;
  lvlMask_t atOrAbove;

  assign ackLvl    = reqPrio[ackSrc*PRIO_W +: PRIO_W];
  assign atOrAbove = (lvlMask_t'(2) << ackLvl) - lvlMask_t'(1);

  p_no_ack_disabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
    intDisable |-> !ackValid);
  p_no_ack_nmi_exc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (nmiAck || excAck) |-> !ackValid);
  p_nest_strict_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ackValid |-> ((inService & atOrAbove) == '0));
  p_ack_marks_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ackValid |=> inService[$past(ackLvl)]);
  p_ack_sets_disable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ackValid |=> intDisable);
  p_di_sets_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdDi && !flagWrEn && !ackValid) |=> intDisable);
  p_reti_one_bit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdReti && retiMaskable && !ackValid && (inService != '0)) |=>
      ($countones(inService) + 1 == $past($countones(inService))));
  p_reti_nm_keeps_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdReti && !retiMaskable && !ackValid) |=> (inService == $past(inService)));
endmodule

bind mask_irq_arbiter mask_irq_arbiter_chk #(.NUM_SRC(NUM_SRC)) uChk (
  .clk(clk), .rst_n(rst_n), .reqPrio(reqPrio), .cmdDi(cmdDi),
  .cmdReti(cmdReti), .retiMaskable(retiMaskable), .flagWrEn(flagWrEn),
  .nmiAck(nmiAck), .excAck(excAck), .ackValid(ackValid), .ackSrc(ackSrc),
  .inService(inService), .intDisable(intDisable)
);

// File: tb/mask_irq_arbiter_test.sv
module mask_irq_arbiter_test;
  localparam int NS = 8;
  localparam int PW = 3;
  localparam int SW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NS-1:0]    reqSet = '0;
  logic [NS*PW-1:0] reqPrio = '1;
  logic cmdDi = 0, cmdEi = 0, cmdReti = 0, retiMaskable = 0;
  logic flagWrEn = 0, flagWrData = 0, nmiAck = 0, excAck = 0;
  logic          ackValid;
  logic [SW-1:0] ackSrc;
  logic [7:0]    inService;
  logic          intDisable;

  int nTests = 0;
  int nFail  = 0;

  logic [NS-1:0] mPend;
  logic [7:0]    mIsr;
  logic          mDis;

  always #10 clk = ~clk;

  mask_irq_arbiter #(.NUM_SRC(NS)) uut (
    .clk(clk), .rst_n(rst_n), .reqSet(reqSet), .reqPrio(reqPrio),
    .cmdDi(cmdDi), .cmdEi(cmdEi), .cmdReti(cmdReti),
    .retiMaskable(retiMaskable), .flagWrEn(flagWrEn),
    .flagWrData(flagWrData), .nmiAck(nmiAck), .excAck(excAck),
    .ackValid(ackValid), .ackSrc(ackSrc), .inService(inService),
    .intDisable(intDisable)
  );

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [PW-1:0] prioOf(input int i);
    return reqPrio[i*PW +: PW];
  endfunction

  task automatic idle();
    reqSet = '0; cmdDi = 0; cmdEi = 0; cmdReti = 0; retiMaskable = 0;
    flagWrEn = 0; flagWrData = 0; nmiAck = 0; excAck = 0;
  endtask

  // inputs are already applied just after a falling edge
  task automatic step(input string tag);
    int  ceilL, bestP, bestI;
    bit  found, eAck;
    logic [7:0] nIsr;
    #1;
    ceilL = 8;
    for (int l = 7; l >= 0; l--) if (mIsr[l]) ceilL = l;
    found = 0; bestP = 0; bestI = 0;
    for (int i = 0; i < NS; i++) begin
      if (mPend[i] && int'(prioOf(i)) < ceilL && (!found || int'(prioOf(i)) < bestP)) begin
        found = 1; bestP = int'(prioOf(i)); bestI = i;
      end
    end
    eAck = found && !mDis && !nmiAck && !excAck;
    check(tag, "ackValid", 32'(ackValid), 32'(eAck));
    if (eAck) check(tag, "ackSrc", 32'(ackSrc), 32'(bestI));
    check(tag, "inService", 32'(inService), 32'(mIsr));
    check(tag, "intDisable", 32'(intDisable), 32'(mDis));
    @(posedge clk);
    nIsr = mIsr;
    if (cmdReti && retiMaskable) begin
      for (int l = 0; l < 8; l++) begin
        if (mIsr[l]) begin nIsr[l] = 1'b0; break; end
      end
    end
    if (eAck) begin
      nIsr[bestP] = 1'b1;
      mPend[bestI] = 1'b0;
    end
    mIsr  = nIsr;
    mPend = mPend | reqSet;
    if (eAck) mDis = 1'b1;
    else if (flagWrEn) mDis = flagWrData;
    else if (cmdDi) mDis = 1'b1;
    else if (cmdEi) mDis = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd4711);
    mPend = '0; mIsr = '0; mDis = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle();
    step("R1");

    // priorities: src6=2, src1=5, src3=5, rest 7
    reqPrio = '1;
    reqPrio[6*PW +: PW] = 3'd2;
    reqPrio[1*PW +: PW] = 3'd5;
    reqPrio[3*PW +: PW] = 3'd5;
    reqSet = 8'b0100_1010; step("R2");
    idle(); step("R5"); step("R5");
    cmdEi = 1; step("R8");
    idle(); step("R3");            // src6 granted
    step("R6");                    // level 2 in service, flag set (R7)
    cmdEi = 1; step("R8");
    idle(); step("R4");            // level 5 blocked by level 2
    cmdReti = 1; retiMaskable = 0; step("R10");
    idle(); step("R10");
    nmiAck = 1; step("R10");
    idle(); excAck = 1; step("R10");
    idle(); cmdReti = 1; retiMaskable = 1; step("R9");
    // grant src1 (tie with src3), with re-request and flag write colliding
    idle(); reqSet = 8'b0000_0010; flagWrEn = 1; flagWrData = 0; cmdEi = 1;
    step("R7");
    idle(); step("R2");
    cmdEi = 1; step("R8");
    idle(); step("R4");
    cmdReti = 1; retiMaskable = 1; step("R9");
    idle(); nmiAck = 1; step("R5");
    idle(); step("R3");
    step("R6");
    cmdReti = 1; retiMaskable = 1; step("R9");
    step("R9");                    // register already empty
    idle(); flagWrEn = 1; flagWrData = 0; cmdDi = 1; step("R8");
    idle(); cmdDi = 1; cmdEi = 1; step("R8");
    idle(); step("R8");

    for (int n = 0; n < 3000; n++) begin
      idle();
      for (int i = 0; i < NS; i++) reqSet[i] = ($urandom % 10) == 0;
      if (($urandom % 16) == 0) reqPrio = (NS*PW)'($urandom);
      cmdEi        = ($urandom % 10) < 3;
      cmdDi        = ($urandom % 20) == 0;
      flagWrEn     = ($urandom % 20) == 0;
      flagWrData   = 1'($urandom);
      cmdReti      = ($urandom % 5) == 0;
      retiMaskable = ($urandom % 10) < 7;
      nmiAck       = ($urandom % 20) == 0;
      excAck       = ($urandom % 20) == 0;
      step("R3");
    end

    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule